// File: doc/BRIEF.md
# Bus Selection Response Filter

This block judges the ID and parity pattern that a target captures from a parallel SCSI-style data bus while it is being selected or reselected. The bus carries one line per device ID, sixteen in all, and one odd-parity bit for each byte lane. When the surrounding phase logic pulses a selection-valid strobe, the filter decides in a single cycle whether the pattern is a selection this target should answer. It registers the verdict, so an accept pulse or a parity-error pulse appears one clock after the strobe. It also presents the ID of the initiator that did the selecting.

Three controls shape the verdict. A parity enable turns every parity check on or off. A single-initiator disable makes the target ignore the legacy form of selection, in which only the target's own ID line is driven. This guards against a one-bit bus error being read as a valid selection. A high-parity control tells the filter that every device on the bus is 16 bits wide, so the upper lane's parity bit must always be valid. A device that is only 8 bits wide leaves that line undriven, so its selections are dropped.

Top module: `sel_filter`

## Requirements
- R1: Outputs `accept` and `par_err` are registered single-cycle pulses. They are high only in the cycle after a clock edge at which `sel_valid` was high, and both are low when `sel_valid` was low.
- R2: A pattern in which bit `own_id` of `id_bus` is clear is never accepted.
- R3: A pattern with more than two bits of `id_bus` set is never accepted.
- R4: A pattern with exactly two bits set, one of them the own bit, that passes its parity checks is accepted. `init_id` then gives the index of the other bit and `init_known` is 1.
- R5: With `no_single`=0, a pattern holding only the own bit is accepted (parity permitting), with `init_known`=0 and `init_id`=0. `init_id` and `init_known` load at every strobe and are 0 unless a two-bit selection was accepted.
- R6: With `no_single`=1, a pattern holding only the own bit is not accepted.
- R7: Parity is odd per lane. Lane k covers `id_bus[8k+7:8k]` with `par_bits[k]`. A checked lane fails when the number of 1s among its eight bits and its parity bit is even. Any failing checked lane raises `par_err` and blocks `accept`. `par_err` does not depend on the other rejection rules.
- R8: With `par_en`=0, no lane is checked. `par_err` stays low and bad parity does not block acceptance.
- R9: With `par_en`=1 and `chk_hi`=1, both lanes are checked on every strobe, even when no bit in 15:8 is set. A wrong upper parity bit causes rejection.
- R10: With `chk_hi`=0, the upper lane is never checked. The lower lane is checked only when no bit of `id_bus[15:8]` is set.
- R11: During and right after reset, `accept`, `par_err`, `init_id` and `init_known` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_valid | input | 1 | Strobe: the bus pattern is a captured selection |
| id_bus | input | 16 | Sampled ID lines, one per device ID |
| par_bits | input | 2 | Odd parity bits, bit 0 for IDs 7:0 and bit 1 for IDs 15:8 |
| own_id | input | 4 | This target's ID |
| par_en | input | 1 | Enable parity checking |
| no_single | input | 1 | Ignore selections that carry only the own ID |
| chk_hi | input | 1 | Always check upper-lane parity |
| accept | output | 1 | Pulse: selection accepted |
| par_err | output | 1 | Pulse: a checked lane failed parity |
| init_id | output | 4 | Index of the selecting initiator |
| init_known | output | 1 | `init_id` is valid |

## Verification
The hardest case to reach is the interaction between lane choice and ID position. The upper lane must be checked when the upper byte holds no set bit at all. The lower lane must be skipped when one of the two IDs sits in the upper byte. Neither case shows up with ordinary low-numbered IDs and correct parity. The stimulus therefore deliberately corrupts one parity bit while placing the own ID or the initiator ID in each byte lane, with the high-parity control both set and clear. Back-to-back strobes check that each verdict stays aligned with its own pattern.

// File: rtl/sel_pkg.sv
package sel_pkg;
  localparam int unsigned ID_W    = 16;
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned N_LANES = ID_W / LANE_W;
  localparam int unsigned IDX_W   = $clog2(ID_W);
  localparam int unsigned CNT_W   = $clog2(ID_W + 1);
endpackage

// File: rtl/sel_lane_par.sv
module sel_lane_par #(
  parameter int unsigned LANE_W = sel_pkg::LANE_W
) (
  input  logic [LANE_W-1:0] lane_bits,
  input  logic              lane_par,
  output logic              lane_fail
);
  // odd parity: total of ones including parity must be odd
  always_comb begin
    lane_fail = ~((^lane_bits) ^ lane_par);
  end
endmodule

// File: rtl/sel_id_decode.sv
module sel_id_decode #(
  parameter int unsigned ID_W   = sel_pkg::ID_W,
  parameter int unsigned LANE_W = sel_pkg::LANE_W,
  localparam int unsigned IDX_W = $clog2(ID_W),
  localparam int unsigned CNT_W = $clog2(ID_W + 1)
) (
  input  logic [ID_W-1:0]  id_bus,
  input  logic [IDX_W-1:0] own_id,
  output logic             own_hit,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [IDX_W-1:0] other_idx,
  output logic             upper_any
);
  logic [ID_W-1:0] others;

  always_comb begin
    own_hit   = id_bus[own_id];
    others    = id_bus;
    others[own_id] = 1'b0;
    bit_cnt   = '0;
    other_idx = '0;
    upper_any = 1'b0;
    for (int i = 0; i < ID_W; i++) begin
      bit_cnt = bit_cnt + CNT_W'(id_bus[i]);
      if (others[i]) other_idx = IDX_W'(i);
      if (i >= LANE_W && id_bus[i]) upper_any = 1'b1;
    end
  end
endmodule

// File: rtl/sel_filter.sv
module sel_filter #(
  parameter int unsigned ID_W   = sel_pkg::ID_W,
  parameter int unsigned LANE_W = sel_pkg::LANE_W,
  localparam int unsigned N_LANES = ID_W / LANE_W,
  localparam int unsigned IDX_W   = $clog2(ID_W),
  localparam int unsigned CNT_W   = $clog2(ID_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_valid,
  input  logic [ID_W-1:0]    id_bus,
  input  logic [N_LANES-1:0] par_bits,
  input  logic [IDX_W-1:0]   own_id,
  input  logic               par_en,
  input  logic               no_single,
  input  logic               chk_hi,
  output logic               accept,
  output logic               par_err,
  output logic [IDX_W-1:0]   init_id,
  output logic               init_known
);
  logic             own_hit;
  logic [CNT_W-1:0] bit_cnt;
  logic [IDX_W-1:0] other_idx;
  logic             upper_any;
  logic [N_LANES-1:0] lane_fail;
  logic [N_LANES-1:0] lane_chk;

  sel_id_decode #(.ID_W(ID_W), .LANE_W(LANE_W)) u_dec (
    .id_bus    (id_bus),
    .own_id    (own_id),
    .own_hit   (own_hit),
    .bit_cnt   (bit_cnt),
    .other_idx (other_idx),
    .upper_any (upper_any)
  );

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    sel_lane_par #(.LANE_W(LANE_W)) u_par (
      .lane_bits (id_bus[k*LANE_W +: LANE_W]),
      .lane_par  (par_bits[k]),
      .lane_fail (lane_fail[k])
    );
    if (k == 0) begin : g_low
      assign lane_chk[k] = par_en & (chk_hi | ~upper_any);
    end else begin : g_high
      assign lane_chk[k] = par_en & chk_hi;
    end
  end

  // next-state logic
  logic             par_bad, pair_ok, lone_ok, struct_ok;
  logic             accept_d, par_err_d, known_d;
  logic [IDX_W-1:0] init_d;
  logic             info_en;

  always_comb begin
    par_bad   = |(lane_fail & lane_chk);
    pair_ok   = own_hit & (bit_cnt == CNT_W'(2));
    lone_ok   = own_hit & (bit_cnt == CNT_W'(1)) & ~no_single;
    struct_ok = pair_ok | lone_ok;
    accept_d  = sel_valid & struct_ok & ~par_bad;
    par_err_d = sel_valid & par_bad;
    known_d   = accept_d & pair_ok;
    init_d    = known_d ? other_idx : '0;
    info_en   = sel_valid;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept  <= 1'b0;
      par_err <= 1'b0;
    end else begin
      accept  <= accept_d;
      par_err <= par_err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_id    <= '0;
      init_known <= 1'b0;
    end else if (info_en) begin
      init_id    <= init_d;
      init_known <= known_d;
    end
  end

  // R1
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept || par_err) |-> $past(sel_valid));
  // R7
  acc_vs_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && par_err));
  // R2
  own_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(id_bus[own_id]));
  // R3
  max_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ($past($countones(id_bus)) <= 2));
  // R6
  no_lone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !($past(no_single) && $past($countones(id_bus)) == 1));
  // R8
  par_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> $past(par_en));
  // R5
  known_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_known |-> (accept || $stable(init_known)));
endmodule

// File: tb/sim_sel_filter.sv
`timescale 1ns/1ps
module sim_sel_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel_valid;
  logic [15:0] id_bus;
  logic [1:0]  par_bits;
  logic [3:0]  own_id;
  logic        par_en, no_single, chk_hi;
  logic        accept, par_err, init_known;
  logic [3:0]  init_id;

  always #2.5 clk = ~clk;

  sel_filter u0 (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .id_bus(id_bus),
    .par_bits(par_bits), .own_id(own_id), .par_en(par_en),
    .no_single(no_single), .chk_hi(chk_hi), .accept(accept),
    .par_err(par_err), .init_id(init_id), .init_known(init_known)
  );

  typedef struct packed {
    logic       acc;
    logic       perr;
    logic       known;
    logic [3:0] id;
  } exp_t;

  exp_t  sb_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  function automatic logic odd_bit(input logic [7:0] b);
    return ~(^b);
  endfunction

  // expected result from the requirement text
  function automatic exp_t model(input logic [15:0] ids, input logic [1:0] pb,
                                 input logic [3:0] own, input logic pe,
                                 input logic ns, input logic ch);
    exp_t e;
    int n;
    logic lo_bad, hi_bad, bad, ok;
    int other;
    n = $countones(ids);
    lo_bad = ($countones({ids[7:0], pb[0]}) % 2) == 0;
    hi_bad = ($countones({ids[15:8], pb[1]}) % 2) == 0;
    bad = 1'b0;
    if (pe) begin
      if (ch) bad = lo_bad | hi_bad;
      else if (ids[15:8] == 8'h00) bad = lo_bad;
    end
    other = 0;
    for (int i = 0; i < 16; i++) if (ids[i] && i != int'(own)) other = i;
    ok = ids[own] && (n == 2 || (n == 1 && !ns));
    e.perr  = bad;
    e.acc   = ok && !bad;
    e.known = e.acc && n == 2;
    e.id    = e.known ? 4'(other) : 4'd0;
    return e;
  endfunction

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input string req, input logic [15:0] ids,
                       input logic [1:0] pb, input logic [3:0] own,
                       input logic pe, input logic ns, input logic ch);
    @(negedge clk);
    id_bus = ids; par_bits = pb; own_id = own;
    par_en = pe; no_single = ns; chk_hi = ch;
    sel_valid = 1'b1;
    sb_q.push_back(model(ids, pb, own, pe, ns, ch));
    tag_q.push_back(req);
  endtask

  task automatic idle();
    @(negedge clk);
    sel_valid = 1'b0;
  endtask

  // monitor: outputs settle after the edge that captured the strobe
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && sel_valid && sb_q.size() > 0) begin
        exp_t e;
        string t;
        e = sb_q.pop_front();
        t = tag_q.pop_front();
        check(t, "accept",     int'(accept),     int'(e.acc));
        check(t, "par_err",    int'(par_err),    int'(e.perr));
        check(t, "init_known", int'(init_known), int'(e.known));
        check(t, "init_id",    int'(init_id),    int'(e.id));
      end else if (rst_n && !sel_valid && !done) begin
        // R1: no pulse without a strobe
        check("R1", "idle pulse", int'(accept | par_err), 0);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; sel_valid = 1'b0; id_bus = '0; par_bits = '0;
    own_id = 4'd5; par_en = 1'b1; no_single = 1'b0; chk_hi = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "accept",     int'(accept),     0);
    check("R11", "par_err",    int'(par_err),    0);
    check("R11", "init_id",    int'(init_id),    0);
    check("R11", "init_known", int'(init_known), 0);
    rst_n = 1'b1;
    idle();
    // R4 pair in low lane, correct parity
    v = 16'h0024;
    drive("R4", v, {odd_bit(v[15:8]), odd_bit(v[7:0])}, 4'd5, 1, 0, 0);
    idle();
    // R2 own bit absent
    v = 16'h0088;
    drive("R2", v, {odd_bit(v[15:8]), odd_bit(v[7:0])}, 4'd5, 1, 0, 0);
    // R3 three bits (back-to-back strobe)
    v = 16'h0228;
    drive("R3", v, {odd_bit(v[15:8]), odd_bit(v[7:0])}, 4'd5, 1, 0, 0);
    idle();
    // R5 lone own bit allowed
    v = 16'h0020;
    drive("R5", v, {odd_bit(v[15:8]), odd_bit(v[7:0])}, 4'd5, 1, 0, 0);
    // R6 lone own bit refused
    drive("R6", v, {odd_bit(v[15:8]), odd_bit(v[7:0])}, 4'd5, 1, 1, 0);
    // R6 pair still accepted with no_single set
    v = 16'h0021;
    drive("R6", v, {odd_bit(v[15:8]), odd_bit(v[7:0])}, 4'd5, 1, 1, 0);
    idle();
    // R7 bad low parity
    v = 16'h0024;
    drive("R7", v, {odd_bit(v[15:8]), ~odd_bit(v[7:0])}, 4'd5, 1, 0, 0);
    // R8 same pattern, checking disabled
    drive("R8", v, {~odd_bit(v[15:8]), ~odd_bit(v[7:0])}, 4'd5, 0, 0, 1);
    idle();
    // R9 upper byte empty, upper parity undriven low -> fails
    drive("R9", v, {1'b0, odd_bit(v[7:0])}, 4'd5, 1, 0, 1);
    // R9 upper parity correct -> accepted
    drive("R9", v, {1'b1, odd_bit(v[7:0])}, 4'd5, 1, 0, 1);
    // R9 own id in upper lane, bad upper parity
    v = 16'h2002;
    drive("R9", v, {~odd_bit(v[15:8]), odd_bit(v[7:0])}, 4'd13, 1, 0, 1);
    idle();
    // R10 upper parity ignored when chk_hi clear
    v = 16'h0024;
    drive("R10", v, {~odd_bit(v[15:8]), odd_bit(v[7:0])}, 4'd5, 1, 0, 0);
    // R10 initiator in upper lane: low lane not checked
    v = 16'h1020;
    drive("R10", v, {~odd_bit(v[15:8]), ~odd_bit(v[7:0])}, 4'd5, 1, 0, 0);
    // R10 same with chk_hi set: both lanes checked -> error
    drive("R10", v, {~odd_bit(v[15:8]), ~odd_bit(v[7:0])}, 4'd5, 1, 0, 1);
    // R4 upper-lane pair, all parity good, init id 12
    drive("R4", v, {odd_bit(v[15:8]), odd_bit(v[7:0])}, 4'd5, 1, 0, 1);
    idle();
    // R5 after a rejection the initiator info clears
    v = 16'h0800;
    drive("R5", v, {odd_bit(v[15:8]), odd_bit(v[7:0])}, 4'd5, 1, 0, 0);
    idle();
    // R4 sweep of initiators against own id 0
    for (int i = 1; i < 16; i++) begin
      v = 16'h0001 | (16'h0001 << i);
      drive("R4", v, {odd_bit(v[15:8]), odd_bit(v[7:0])}, 4'd0, 1, 1, 1);
    end
    idle();
    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule